// File: doc/BRIEF.md
# Data Clock Divider with Phase Slip

This block produces the output data clock of a converter from its sample clock. The clock either passes straight through (divide by 1) or is halved by a toggle flop (divide by 2). The divisor normally follows a pin setting that has already been decoded. A divisor-select register can override that pin setting. A soft reset does not touch the divisor-select register.

Several converters can share one capture device. To line up their data clocks, software can request a phase slip. It first writes 0 to the slip bit and then writes 1. The block brings that bit into the sample-clock domain and detects its rising transition. On that transition the toggle flop skips exactly one toggle. The divided clock then falls one input period away from its previous alignment. A small register port writes and reads both control registers.

Top module: `dclk_divider`

## Requirements
- R1: While rst_n is low and right after it rises, the divisor-select field reads 000, the slip bit reads 0 and sel_bad is 0.
- R2: With select code 000 the divisor follows pin_div2: 1 selects divide by 2 and 0 selects divide by 1.
- R3: Code 001 forces divide by 1 and code 010 forces divide by 2, whatever the value of pin_div2.
- R4: Codes 011 to 111 behave as divide by 1 and raise sel_bad. Codes 000 to 010 keep sel_bad low.
- R5: Reading address 0x72 returns the select code in bits [2:0], with the upper bits zero. Reading 0x71 returns the slip bit in bit 0. Any other address reads zero.
- R6: In divide-by-2 mode, a 0-to-1 change of the slip bit makes dclk_out hold its level for one extra input period, exactly once. The held edge is the third rising edge after the edge that stores the 1.
- R7: Writing 1 to a slip bit that already holds 1 causes no slip.
- R8: In divide-by-1 mode dclk_out equals clk_in, before, during and after a slip request.
- R9: A soft_rst pulse clears the slip bit. It leaves the divisor-select field and the selected divisor unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset, one cycle, active high |
| pin_div2 | input | 1 | Decoded pin divisor: 1 selects divide by 2 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| dclk_out | output | 1 | Output data clock |
| sel_bad | output | 1 | The select field holds a code that is not allowed |

## Verification
A write to the select register takes effect in the same cycle the write is stored. The mode check therefore samples dclk_out at the next falling edge, two time units after the following rising edge, and at the falling edge after that. A slip request crosses two synchronizer stages and one edge-detect flop, so the held level shows at the third rising edge after the write. The bench records eight successive falling-edge samples and requires exactly one repeated level, at index 3. Readback is combinational and is checked in the same half cycle as the address is applied.

// File: rtl/dclk_div_pkg.sv
package dclk_div_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_PIN  = 3'b000;
  localparam logic [SEL_W-1:0] SEL_DIV1 = 3'b001;
  localparam logic [SEL_W-1:0] SEL_DIV2 = 3'b010;

  function automatic logic code_is_bad(input logic [SEL_W-1:0] code);
    return (code != SEL_PIN) && (code != SEL_DIV1) && (code != SEL_DIV2);
  endfunction

  function automatic logic pick_div2(input logic [SEL_W-1:0] code, input logic pin);
    logic r;
    case (code)
      SEL_PIN:  r = pin;
      SEL_DIV2: r = 1'b1;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dclk_cfg_regs.sv
module dclk_cfg_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  parameter logic [ADDR_W-1:0] SLIP_ADDR = 8'h71,
  parameter logic [ADDR_W-1:0] DIV_ADDR  = 8'h72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [SEL_W-1:0]  sel_q,
  output logic              slip_q
);
  localparam int PAD_SEL  = DATA_W - SEL_W;
  localparam int PAD_SLIP = DATA_W - 1;

  logic             sel_en;
  logic [SEL_W-1:0] sel_d;
  logic             slip_en;
  logic             slip_d;

  // divisor select: only a write changes it, soft reset never does
  always_comb begin
    sel_en = wr_en && (wr_addr == DIV_ADDR);
    sel_d  = wr_data[SEL_W-1:0];
  end

  // slip bit: soft reset has priority over a write
  always_comb begin
    slip_en = soft_rst || (wr_en && (wr_addr == SLIP_ADDR));
    slip_d  = soft_rst ? 1'b0 : wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       slip_q <= 1'b0;
    else if (slip_en) slip_q <= slip_d;
  end

  always_comb begin
    if (rd_addr == DIV_ADDR)       rd_data = {{PAD_SEL{1'b0}}, sel_q};
    else if (rd_addr == SLIP_ADDR) rd_data = {{PAD_SLIP{1'b0}}, slip_q};
    else                           rd_data = '0;
  end
endmodule

// File: rtl/dclk_slip_detect.sv
module dclk_slip_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic slip_bit,
  output logic slip_pulse
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = soft_rst ? '0 : slip_bit;
    end else begin : g_many
      always_comb sync_d = soft_rst ? '0 : {sync_q[SYNC_STAGES-2:0], slip_bit};
    end
  endgenerate

  always_comb prev_d = soft_rst ? 1'b0 : sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign slip_pulse = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/dclk_toggle_gen.sv
module dclk_toggle_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic div2_sel,
  input  logic slip_pulse,
  output logic tog_q
);
  logic tog_en;
  logic tog_d;

  // a slip only counts in divide-by-2 mode: it suppresses one toggle
  always_comb begin
    tog_en = soft_rst || !(div2_sel && slip_pulse);
    tog_d  = soft_rst ? 1'b0 : ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= 1'b0;
    else if (tog_en) tog_q <= tog_d;
  end
endmodule

// File: rtl/dclk_divider.sv
module dclk_divider
  import dclk_div_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] SLIP_ADDR = 8'h71,
  parameter logic [ADDR_W-1:0] DIV_ADDR  = 8'h72
) (
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              pin_div2,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              dclk_out,
  output logic              sel_bad
);
  logic [SEL_W-1:0] sel_q;
  logic             slip_q;
  logic             slip_pulse;
  logic             div2_sel;
  logic             tog_q;

  dclk_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
    .SLIP_ADDR(SLIP_ADDR), .DIV_ADDR(DIV_ADDR)
  ) u_regs (
    .clk(clk_in), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .sel_q(sel_q), .slip_q(slip_q)
  );

  dclk_slip_detect #(.SYNC_STAGES(SYNC_STAGES)) u_slip (
    .clk(clk_in), .rst_n(rst_n), .soft_rst(soft_rst),
    .slip_bit(slip_q), .slip_pulse(slip_pulse)
  );

  always_comb begin
    div2_sel = pick_div2(sel_q, pin_div2);
    sel_bad  = code_is_bad(sel_q);
  end

  dclk_toggle_gen u_tog (
    .clk(clk_in), .rst_n(rst_n), .soft_rst(soft_rst),
    .div2_sel(div2_sel), .slip_pulse(slip_pulse), .tog_q(tog_q)
  );

  assign dclk_out = div2_sel ? tog_q : clk_in;
endmodule

// File: rtl/dclk_divider_chk.sv
module dclk_divider_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             wr_en,
  input logic             div2_sel,
  input logic             slip_pulse,
  input logic             tog_q,
  input logic             sel_bad,
  input logic [SEL_W-1:0] sel_q
);
  // R4: an illegal code is non-zero and never picks divide by 2
  a_r4_bad_is_div1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_bad |-> (sel_q != '0) && !div2_sel);

  // R6: a slip in divide-by-2 mode holds the toggle for one edge
  a_r6_slip_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_pulse && div2_sel && !soft_rst) |=> (tog_q == $past(tog_q)));

  // R6: without a slip the divide-by-2 toggle changes at every edge
  a_r6_free_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (!slip_pulse && div2_sel && !soft_rst) |=> (tog_q != $past(tog_q)));

  // R7: one transition of the slip bit gives a single-cycle pulse
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    slip_pulse |=> !slip_pulse);

  // R9: a soft reset leaves the divisor select alone
  a_r9_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !wr_en) |=> $stable(sel_q));
endmodule

bind dclk_divider dclk_divider_chk #(.SEL_W(dclk_div_pkg::SEL_W)) u_chk (
  .clk(clk_in), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
  .div2_sel(div2_sel), .slip_pulse(slip_pulse), .tog_q(tog_q),
  .sel_bad(sel_bad), .sel_q(sel_q)
);

// File: tb/dclk_divider_tb.sv
`timescale 1ns/1ps
module dclk_divider_tb;
  logic       clk_in = 1'b0;
  logic       rst_n;
  logic       soft_rst;
  logic       pin_div2;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_addr;
  logic [7:0] rd_data;
  logic       dclk_out;
  logic       sel_bad;

  int total = 0;
  int bad   = 0;

  always #5 clk_in = ~clk_in;

  dclk_divider u_dut (
    .clk_in(clk_in), .rst_n(rst_n), .soft_rst(soft_rst), .pin_div2(pin_div2),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .dclk_out(dclk_out), .sel_bad(sel_bad)
  );

  // {code[2:0], pin, expect_div2, expect_bad}
  localparam logic [5:0] VEC [8] = '{
    {3'b000, 1'b0, 1'b0, 1'b0},
    {3'b000, 1'b1, 1'b1, 1'b0},
    {3'b001, 1'b1, 1'b0, 1'b0},
    {3'b010, 1'b0, 1'b1, 1'b0},
    {3'b011, 1'b1, 1'b0, 1'b1},
    {3'b111, 1'b0, 1'b0, 1'b1},
    {3'b100, 1'b1, 1'b0, 1'b1},
    {3'b010, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_in);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk_in);
    wr_en = 1'b0;
  endtask

  // returns 1 for divide by 2, 0 for divide by 1, 2 for neither
  task automatic probe_mode(output int mode);
    logic a, b, c;
    @(negedge clk_in); a = dclk_out;
    #7;                b = dclk_out;
    @(negedge clk_in); c = dclk_out;
    if (!a && b && !c)              mode = 0;
    else if (b == c && b != a)      mode = 1;
    else                            mode = 2;
  endtask

  // eight falling-edge samples starting at the current one; returns repeat count and last repeat index
  task automatic slip_window(output int reps, output int idx);
    logic prev;
    reps = 0; idx = -1;
    prev = dclk_out;
    for (int k = 1; k < 8; k++) begin
      @(negedge clk_in);
      if (dclk_out == prev) begin reps++; idx = k; end
      prev = dclk_out;
    end
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int mode, reps, idx;
    rst_n = 1'b0; soft_rst = 1'b0; pin_div2 = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = 8'h72;
    #23;
    // R1 in reset
    check(rd_data == 8'h00, "R1 select in reset", rd_data, 0);
    check(sel_bad == 1'b0, "R1 sel_bad in reset", sel_bad, 0);
    @(negedge clk_in); rst_n = 1'b1;
    rd_addr = 8'h71; #1;
    check(rd_data == 8'h00, "R1 slip bit after reset", rd_data, 0);
    probe_mode(mode);
    check(mode == 0, "R1 R2 pin 0 gives div1 after reset", mode, 0);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 8; i++) begin
      pin_div2 = VEC[i][2];
      wr(8'h72, {5'b10101, VEC[i][5:3]});
      rd_addr = 8'h72; #1;
      check(rd_data == {5'b0, VEC[i][5:3]}, "R5 select readback", rd_data, VEC[i][5:3]);
      check(sel_bad == VEC[i][0], "R4 sel_bad", sel_bad, VEC[i][0]);
      probe_mode(mode);
      check(mode == int'(VEC[i][1]), "R2 R3 R4 divisor", mode, VEC[i][1]);
    end

    // R5 unused address
    rd_addr = 8'h70; #1;
    check(rd_data == 8'h00, "R5 unused address", rd_data, 0);

    // R6 slip in divide by 2
    wr(8'h72, 8'h02);
    wr(8'h71, 8'h00);
    repeat (3) @(negedge clk_in);
    wr(8'h71, 8'h01);
    rd_addr = 8'h71; #1;
    check(rd_data == 8'h01, "R5 slip bit readback", rd_data, 1);
    slip_window(reps, idx);
    check(reps == 1, "R6 exactly one held level", reps, 1);
    check(idx == 3, "R6 held level position", idx, 3);
    slip_window(reps, idx);
    check(reps == 0, "R6 no further slip", reps, 0);

    // R7 rewrite 1 without 0
    wr(8'h71, 8'h01);
    slip_window(reps, idx);
    check(reps == 0, "R7 repeated 1 gives no slip", reps, 0);

    // second slip after 0 then 1
    wr(8'h71, 8'h00);
    repeat (3) @(negedge clk_in);
    wr(8'h71, 8'h01);
    slip_window(reps, idx);
    check(reps == 1 && idx == 3, "R6 second slip", idx, 3);

    // R8 slip in divide by 1
    wr(8'h72, 8'h01);
    wr(8'h71, 8'h00);
    wr(8'h71, 8'h01);
    for (int k = 0; k < 4; k++) begin
      probe_mode(mode);
      check(mode == 0, "R8 div1 unaffected by slip", mode, 0);
    end

    // R9 soft reset
    wr(8'h72, 8'h02);
    @(negedge clk_in); soft_rst = 1'b1;
    @(negedge clk_in); soft_rst = 1'b0;
    rd_addr = 8'h72; #1;
    check(rd_data == 8'h02, "R9 select kept", rd_data, 2);
    rd_addr = 8'h71; #1;
    check(rd_data == 8'h00, "R9 slip bit cleared", rd_data, 0);
    probe_mode(mode);
    check(mode == 1, "R9 divisor kept", mode, 1);
    slip_window(reps, idx);
    check(reps == 0, "R9 no slip from soft reset", reps, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule